// File: doc/BRIEF.md
# RGB333 Palette Write Port

This block holds a set of colour palettes, each 256 entries deep, where every entry is a 9-bit RGB333 colour plus one priority flag. A processor-side write stream addresses three small registers: an entry index, a control byte whose field picks the palette being written, and a value register. A colour reaches the value register as two byte writes in a row. The first byte holds red, green and the upper blue bits. The second byte holds the lowest blue bit and the priority flag. The entry is written only when the second byte arrives. The index then moves to the next entry, so a run of byte pairs fills consecutive entries.

A separate lookup port lets the display pipeline read any entry of any palette by index. The result appears one cycle after the request.

The write stream uses valid/ready. `wr_ready` is low while reset is held and high at all times after it. A byte is accepted on a rising edge where both `wr_valid` and `wr_ready` are high. The block never applies back-pressure outside reset, so a source may issue one write every cycle. The lookup port has no handshake: each cycle with `rd_en` high produces exactly one result.

Top module: `pal_top`

## Requirements
- R1: After reset the index is 0, the value register expects a first byte, the control byte is 0 (palette 0 targeted), and `lk_valid` is low.
- R2: In the first value byte, bits 7-5 are the 3-bit red, bits 4-2 are the 3-bit green, and bits 1-0 are blue bits 2-1 of the entry.
- R3: In the second value byte, bit 7 is the priority flag and bit 0 is blue bit 0. Bits 6-1 have no effect.
- R4: A first value byte on its own changes no palette entry. The entry is written at the edge that accepts the second byte.
- R5: After each accepted second byte, the index increases by one, and it wraps from 255 to 0.
- R6: A write to the index register (select code 0) loads the index and makes the next value write count as a first byte.
- R7: Bits 6-4 of the control register (select code 1) choose the target palette, and its other bits have no effect. With a code of NUM_PAL or more, a byte pair writes no palette but still advances the index. A control write leaves the byte-pair phase unchanged.
- R8: A lookup requested with `rd_en` on one rising edge sets `lk_valid` high after that edge, for one cycle, with `lk_data` = {priority, R[2:0], G[2:0], B[2:0]} (bit 9 down to bit 0). Without a request, `lk_valid` is low. A lookup and a write of the same entry on the same edge return the old contents.
- R9: A write with select code 3 changes no register, no entry and no byte-pair phase.
- R10: `wr_ready` is low during reset and high from the first edge after reset onward. A write is taken only when `wr_valid` and `wr_ready` are both high. Register select is 0 index, 1 control, 2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be accepted |
| wr_sel | input | 2 | Register select: 0 index, 1 control, 2 value, 3 none |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Lookup request |
| rd_pal | input | 3 | Palette to look up |
| rd_idx | input | 8 | Entry to look up |
| lk_valid | output | 1 | Lookup result present |
| lk_data | output | 10 | {priority, R, G, B} of the requested entry |

## Verification
The internal state is the index, the byte-pair phase, the held first byte and the palette field, and none of it is visible directly. Each one shows up through lookups of the entries that later writes touch. A phase that has slipped swaps the meaning of the two bytes, so the very next completed pair stores a scrambled colour or lands at the wrong entry. A wrong index or a missed wrap puts a colour at a neighbouring entry and leaves the intended entry stale. Those errors are visible on the first lookup that follows the bad pair. The bench runs a behavioural model next to the design and compares every lookup result in the cycle after the request.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // register select codes on the write stream
  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_VALUE = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int BYTE_W   = 8;
  localparam int COLOUR_W = 9;
  localparam int ENTRY_W  = COLOUR_W + 1;
  localparam int PAL_W    = 3;
  // position of the palette field inside the control byte
  localparam int PAL_LSB  = 4;

  // assemble one stored entry from the two value bytes
  function automatic logic [ENTRY_W-1:0] pack_entry(input logic [BYTE_W-1:0] hi_byte,
                                                    input logic            prio,
                                                    input logic            blue_lsb);
    return {prio, hi_byte, blue_lsb};
  endfunction
endpackage

// File: rtl/pal_wr_regs.sv
module pal_wr_regs
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_fire,
  input  logic [1:0]          wr_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                commit,
  output logic [PAL_W-1:0]    commit_pal,
  output logic [IDX_W-1:0]    commit_idx,
  output logic [ENTRY_W-1:0]  commit_entry,
  output logic [IDX_W-1:0]    idx_q,
  output logic                phase_q,
  output logic [PAL_W-1:0]    pal_sel_q
);
  logic [BYTE_W-1:0] first_q;
  reg_sel_e          sel;
  logic              unused_mid_bits;

  assign sel             = reg_sel_e'(wr_sel);
  assign unused_mid_bits = ^wr_data[BYTE_W-2:1];

  // second byte of a pair completes the entry
  assign commit       = wr_fire && (sel == SEL_VALUE) && phase_q;
  assign commit_pal   = pal_sel_q;
  assign commit_idx   = idx_q;
  assign commit_entry = pack_entry(first_q, wr_data[BYTE_W-1], wr_data[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      phase_q   <= 1'b0;
      pal_sel_q <= '0;
      first_q   <= '0;
    end else if (wr_fire) begin
      unique case (sel)
        SEL_INDEX: begin
          idx_q   <= wr_data[IDX_W-1:0];
          phase_q <= 1'b0;
        end
        SEL_CTRL: begin
          pal_sel_q <= wr_data[PAL_LSB +: PAL_W];
        end
        SEL_VALUE: begin
          if (!phase_q) begin
            first_q <= wr_data;
            phase_q <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            phase_q <= 1'b0;
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/pal_bank.sv
module pal_bank
  import pal_pkg::*;
#(
  parameter int NUM_PAL = 4,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               commit,
  input  logic [PAL_W-1:0]   commit_pal,
  input  logic [IDX_W-1:0]   commit_idx,
  input  logic [ENTRY_W-1:0] commit_entry,
  input  logic               rd_en,
  input  logic [PAL_W-1:0]   rd_pal,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] bank_out [NUM_PAL];
  logic [PAL_W-1:0]   rd_pal_q;

  genvar g;
  generate
    for (g = 0; g < NUM_PAL; g++) begin : g_pal
      logic [ENTRY_W-1:0] mem [DEPTH];
      logic [ENTRY_W-1:0] out_q;
      logic               we;

      assign we = commit && (commit_pal == PAL_W'(g));

      always_ff @(posedge clk) begin
        if (we) mem[commit_idx] <= commit_entry;
        if (rd_en) out_q <= mem[rd_idx];
      end
      assign bank_out[g] = out_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rd_en) rd_pal_q <= rd_pal;
  end

  always_comb begin
    rd_entry = '0;
    for (int i = 0; i < NUM_PAL; i++) begin
      if (rd_pal_q == PAL_W'(i)) rd_entry = bank_out[i];
    end
  end
endmodule

// File: rtl/pal_top.sv
module pal_top
  import pal_pkg::*;
#(
  parameter int NUM_PAL = 4,
  parameter int IDX_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [1:0]         wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [2:0]         rd_pal,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               lk_valid,
  output logic [9:0]         lk_data
);
  logic               ready_q;
  logic               wr_fire;
  logic               commit;
  logic [PAL_W-1:0]   commit_pal;
  logic [IDX_W-1:0]   commit_idx;
  logic [ENTRY_W-1:0] commit_entry;
  logic [IDX_W-1:0]   idx_q;
  logic               phase_q;
  logic [PAL_W-1:0]   pal_sel_q;
  logic               valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= rd_en;
    end
  end

  assign wr_ready = ready_q;
  assign wr_fire  = wr_valid && ready_q;
  assign lk_valid = valid_q;

  pal_wr_regs #(.IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_fire      (wr_fire),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .commit       (commit),
    .commit_pal   (commit_pal),
    .commit_idx   (commit_idx),
    .commit_entry (commit_entry),
    .idx_q        (idx_q),
    .phase_q      (phase_q),
    .pal_sel_q    (pal_sel_q)
  );

  pal_bank #(.NUM_PAL(NUM_PAL), .IDX_W(IDX_W)) u_bank (
    .clk          (clk),
    .commit       (commit),
    .commit_pal   (commit_pal),
    .commit_idx   (commit_idx),
    .commit_entry (commit_entry),
    .rd_en        (rd_en),
    .rd_pal       (rd_pal),
    .rd_idx       (rd_idx),
    .rd_entry     (lk_data)
  );
endmodule

// File: rtl/pal_chk.sv
module pal_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       wr_sel,
  input logic             rd_en,
  input logic             lk_valid,
  input logic [IDX_W-1:0] idx_q,
  input logic             phase_q,
  input logic [2:0]       pal_sel_q
);
  logic fire;
  assign fire = wr_valid && wr_ready;

  a_r10_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> wr_ready);

  a_r6_index_clears_phase: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_sel == 2'd0) |=> !phase_q);

  a_r4_first_byte_holds: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_sel == 2'd2 && !phase_q) |=> (phase_q && $stable(idx_q)));

  a_r5_pair_advances: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_sel == 2'd2 && phase_q) |=> (!phase_q && idx_q == IDX_W'($past(idx_q) + 1'b1)));

  a_r9_spare_select: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_sel == 2'd3) |=> ($stable(idx_q) && $stable(phase_q) && $stable(pal_sel_q)));

  a_r8_result_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> lk_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !lk_valid);
endmodule

bind pal_top pal_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_sel    (wr_sel),
  .rd_en     (rd_en),
  .lk_valid  (lk_valid),
  .idx_q     (idx_q),
  .phase_q   (phase_q),
  .pal_sel_q (pal_sel_q)
);

// File: tb/tb_pal_top.sv
module tb_pal_top;
  localparam int NP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_pal = 3'd0;
  logic [7:0] rd_idx = 8'd0;
  logic       lk_valid;
  logic [9:0] lk_data;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pal_top #(.NUM_PAL(NP), .IDX_W(8)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_pal(rd_pal),
    .rd_idx(rd_idx), .lk_valid(lk_valid), .lk_data(lk_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // entry layout from R2/R3/R8: {prio, R, G, B}
  function automatic logic [9:0] col(input logic [7:0] b0, input logic [7:0] b1);
    return {b1[7], b0, b1[0]};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [9:0] m_mem [NP][256];
  bit         m_ok  [NP][256];
  int         m_idx = 0;
  bit         m_ph = 0;
  int         m_pal = 0;
  logic [7:0] m_b0 = 0;
  bit         exp_v = 0;
  bit         exp_ok = 0;
  logic [9:0] exp_d = 0;

  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < 256; i++) m_ok[p][i] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      m_idx = 0; m_ph = 0; m_pal = 0; exp_v = 0;
    end else begin
      exp_v = rd_en;
      exp_ok = rd_en && (int'(rd_pal) < NP) && m_ok[int'(rd_pal) % NP][rd_idx];
      if (exp_ok) exp_d = m_mem[int'(rd_pal) % NP][rd_idx];
      if (wr_valid && wr_ready) begin
        case (wr_sel)
          2'd0: begin m_idx = wr_data; m_ph = 0; end
          2'd1: m_pal = int'(wr_data[6:4]);
          2'd2: begin
            if (!m_ph) begin m_b0 = wr_data; m_ph = 1; end
            else begin
              if (m_pal < NP) begin
                m_mem[m_pal][m_idx] = col(m_b0, wr_data);
                m_ok[m_pal][m_idx] = 1;
              end
              m_idx = (m_idx + 1) % 256;
              m_ph = 0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model (R8)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R8 model valid", lk_valid, exp_v);
      if (exp_v && exp_ok) chk("R8 model data", lk_data, exp_d);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pair(input logic [7:0] b0, input logic [7:0] b1);
    wr(2'd2, b0);
    wr(2'd2, b1);
  endtask

  task automatic look(input string req, input int p, input int i, input logic [9:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_pal = 3'(p); rd_idx = 8'(i);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, lk_valid, 1'b1);
    chk(req, lk_data, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 ready low in reset", wr_ready, 1'b0);
    chk("R1 no result in reset", lk_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", wr_ready, 1'b1);
    chk("R1 lk_valid idle", lk_valid, 1'b0);

    // R1: reset index 0 and palette 0 targeted
    pair(8'h3A, 8'h01);
    look("R1 reset index and palette", 0, 0, col(8'h3A, 8'h01));

    // R2/R3 field layout, R5 consecutive advance
    wr(2'd1, 8'h10);
    wr(2'd0, 8'd0);
    pair(8'hE5, 8'h81);
    pair(8'h1C, 8'h7E);
    look("R2 first byte layout", 1, 0, 10'h3CB);
    look("R3 second byte ignores bits 6-1", 1, 1, 10'h038);
    @(negedge clk);
    chk("R8 idle after lookup", lk_valid, 1'b0);

    // R4: lone first byte does not write; R6 index write clears phase
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h00);
    look("R4 first byte alone no write", 1, 0, 10'h3CB);
    wr(2'd0, 8'd0);
    pair(8'hFF, 8'h01);
    look("R6 phase restarted", 1, 0, 10'h1FF);
    look("R6 neighbour untouched", 1, 1, 10'h038);

    // R5 wrap 255 -> 0
    wr(2'd0, 8'd255);
    pair(8'h92, 8'h00);
    pair(8'h49, 8'h80);
    look("R5 last entry", 1, 255, col(8'h92, 8'h00));
    look("R5 wrapped to 0", 1, 0, col(8'h49, 8'h80));

    // R7 palette select, other control bits ignored, out-of-range dropped
    wr(2'd0, 8'd5);
    pair(8'h6D, 8'h00);
    wr(2'd1, 8'h8F);
    wr(2'd0, 8'd5);
    pair(8'hB6, 8'h81);
    look("R7 palette 0 written", 0, 5, col(8'hB6, 8'h81));
    look("R7 palette 1 kept", 1, 5, col(8'h6D, 8'h00));
    wr(2'd1, 8'h50);
    wr(2'd0, 8'd5);
    pair(8'h03, 8'h01);
    wr(2'd1, 8'h10);
    pair(8'h20, 8'h00);
    look("R7 dropped pair palette 0", 0, 5, col(8'hB6, 8'h81));
    look("R7 dropped pair palette 1", 1, 5, col(8'h6D, 8'h00));
    look("R7 index advanced past dropped", 1, 6, col(8'h20, 8'h00));
    // control write mid-pair keeps phase
    wr(2'd0, 8'd7);
    wr(2'd2, 8'h55);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h80);
    look("R7 control keeps phase", 2, 7, col(8'h55, 8'h80));

    // R9 spare select and R10 unhandshaken bytes ignored mid-pair
    wr(2'd1, 8'h10);
    wr(2'd0, 8'd9);
    wr(2'd2, 8'h24);
    wr(2'd3, 8'h00);
    @(negedge clk);
    wr_sel = 2'd2; wr_data = 8'hFF; wr_valid = 1'b0;
    @(negedge clk);
    wr(2'd2, 8'h01);
    look("R9 spare select ignored", 1, 9, 10'h049);
    pair(8'hC0, 8'h00);
    look("R10 index unaffected by idle cycle", 1, 10, col(8'hC0, 8'h00));

    // R8 same-edge read/write returns old contents
    wr(2'd0, 8'd9);
    wr(2'd2, 8'h11);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'd2; wr_data = 8'h00;
    rd_en = 1'b1; rd_pal = 3'd1; rd_idx = 8'd9;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    chk("R8 same-edge valid", lk_valid, 1'b1);
    chk("R8 same-edge old data", lk_data, 10'h049);
    look("R8 new data after", 1, 9, col(8'h11, 8'h00));

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule